// File: doc/BRIEF.md
# Two-Stage Latched Interrupt Aggregator

This block collects up to seventeen level interrupt lines and folds them into one interrupt output through two cascaded register banks. The first bank (the host stage) latches each line that is sampled high into a sticky status bit. It produces a combined request only when its global enable bit is set and some status bit is also unmasked. That combined request is the only live bit of the second bank's input register. The second bank (the master stage) latches its masked inputs into its own sticky status, and the interrupt output is high while that status holds any set bit.

Software reaches both banks through one 32-bit register bus addressed by word index, where word index = byte offset / 4. Writes take effect on the clock edge. Reads are combinational from the registered state and have no side effects. Both status registers are cleared by writing ones. The route registers, the polarity register and two firmware-window registers are plain storage and do not affect interrupt behaviour.

Top module: `irqc_top`

## Requirements
- R1: After reset `irq_out` is 0 and every implemented register reads 0, except the firmware read-size register (offset 0x28, word index 10), which reads 0x02000000.
- R2: A high level on `irq_lines[n]` at a clock edge sets bit (31 - n) of the host status register (offset 0x38, index 14), so line 0 sets bit 31 and line 16 sets bit 15. A low level never clears the bit.
- R3: A write to the host status register clears each bit that is 1 in the written value and leaves the other bits unchanged. A line still held high at that edge keeps its bit set.
- R4: The host-stage request is 1 exactly when bit 31 (enable) of the host control register (offset 0x30, index 12) is 1 and host status AND host mask (offset 0x34, index 13) is nonzero. The request reads back as bit 11 (0x800) of the master input register (offset 0x5C, index 23), and every other bit of that register reads 0.
- R5: On every clock edge the master status register (offset 0x50, index 20) takes master status OR (master input AND master mask), where the master mask is at offset 0x54, index 21. A set bit stays set after its input drops, and an input bit that is masked off is never latched.
- R6: A write to the master status register clears each bit that is 1 in the written value. A write of zero changes nothing.
- R7: `irq_out` is 1 exactly when the master status register is nonzero.
- R8: The route registers (offsets 0x08 and 0x0C, indices 2 and 3) and the polarity register (offset 0x58, index 22) read back what was last written, and writing them has no effect on `irq_out`.
- R9: Writes to the master input register are ignored. It always reads the live request value.
- R10: A read of any word index without a register (for example 0, 15 or 63) returns 0xFFFFFFFF. A write to such an index changes no register.
- R11: The error-address register (offset 0x40, index 16) reads 0 and ignores writes.
- R12: The firmware segment register (offset 0x24, index 9) and the firmware read-size register (index 10) read back what was last written.
- R13: A line sampled high at clock edge k with both masks and the enable set shows in host status after edge k and raises `irq_out` after edge k+1, not earlier.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| widx | input | 6 | Register word index (byte offset / 4) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `widx`, combinational |
| irq_lines | input | 17 | Level interrupt inputs, line n maps to host status bit 31-n |
| irq_out | output | 1 | Aggregated interrupt output |

## Verification
The assertions assume that `irq_lines`, `wr_en`, `widx` and `wdata` are synchronous to `clk` and hold known values once reset is released. They also assume a write carries the data it means to clear, so a write strobe with undefined data is out of their scope. The bench changes every input only on the falling edge and releases reset with the write strobe low and all lines low. Each line pulse it applies spans whole cycles, so every sticky and latency property sees a clean, single-edge sample.

// File: rtl/irqc_pkg.sv
// Package: shared widths, register word indices and reset values for the
// two-stage interrupt aggregator. Word index = byte offset / 4.
package irqc_pkg;
    localparam int DATA_W        = 32;
    localparam int IDX_ROUTE_A   = 2;   // 0x08
    localparam int IDX_ROUTE_B   = 3;   // 0x0C
    localparam int IDX_FW_SEG    = 9;   // 0x24
    localparam int IDX_FW_SIZE   = 10;  // 0x28
    localparam int IDX_HCTRL     = 12;  // 0x30
    localparam int IDX_HMASK     = 13;  // 0x34
    localparam int IDX_HSTAT     = 14;  // 0x38
    localparam int IDX_ERRADDR   = 16;  // 0x40
    localparam int IDX_MSTAT     = 20;  // 0x50
    localparam int IDX_MMASK     = 21;  // 0x54
    localparam int IDX_MPOL      = 22;  // 0x58
    localparam int IDX_MINPUT    = 23;  // 0x5C
    localparam int HOST_EN_BIT   = 31;
    localparam int CASCADE_BIT   = 11;
    localparam logic [DATA_W-1:0] FW_SIZE_RST = 32'h0200_0000;
    localparam logic [DATA_W-1:0] UNMAPPED_RD = '1;
endpackage

// File: rtl/irqc_host_stage.sv
// Host stage: control, mask and sticky status registers.
// Assumes irq_lines is synchronous to clk. Line n sets status bit DW-1-n.
// A set from a high line wins over a write-one-to-clear in the same cycle.
module irqc_host_stage #(
    parameter int DW     = 32,
    parameter int NLINES = 17,
    parameter int EN_BIT = 31
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic              wr_mask,
    input  logic              wr_clr,
    input  logic [DW-1:0]     wdata,
    input  logic [NLINES-1:0] lines,
    output logic [DW-1:0]     ctrl_q,
    output logic [DW-1:0]     mask_q,
    output logic [DW-1:0]     stat_q,
    output logic              req_o
);
    logic [DW-1:0] set_vec;
    logic [DW-1:0] clr_vec;

    // Map each incoming line onto its reversed status bit position.
    genvar gi;
    generate
        for (gi = 0; gi < DW; gi++) begin : g_map
            if (gi >= DW - NLINES) begin : g_line
                assign set_vec[gi] = lines[DW-1-gi];
            end else begin : g_none
                assign set_vec[gi] = 1'b0;
            end
        end
    endgenerate

    // Clear pattern applies only during a status write.
    assign clr_vec = wr_clr ? wdata : '0;

    // Control and mask storage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            mask_q <= '0;
        end else begin
            if (wr_ctrl) ctrl_q <= wdata;
            if (wr_mask) mask_q <= wdata;
        end
    end

    // Sticky status: clear requested ones, then merge new high lines.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr_vec) | set_vec;
    end

    // Combined request, gated by the global enable.
    assign req_o = ctrl_q[EN_BIT] && ((stat_q & mask_q) != '0);
endmodule

// File: rtl/irqc_master_stage.sv
// Master stage: route, mask, polarity and sticky status registers plus a
// live input vector whose only driven bit is the cascaded host request.
// Polarity is stored but never applied.
module irqc_master_stage #(
    parameter int DW      = 32,
    parameter int CAS_BIT = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_route_a,
    input  logic          wr_route_b,
    input  logic          wr_mask,
    input  logic          wr_pol,
    input  logic          wr_clr,
    input  logic [DW-1:0] wdata,
    input  logic          cas_i,
    output logic [DW-1:0] route_a_q,
    output logic [DW-1:0] route_b_q,
    output logic [DW-1:0] mask_q,
    output logic [DW-1:0] pol_q,
    output logic [DW-1:0] stat_q,
    output logic [DW-1:0] in_vec,
    output logic          irq_o
);
    logic [DW-1:0] clr_vec;

    // Build the input vector: cascade bit live, others tied low.
    genvar gb;
    generate
        for (gb = 0; gb < DW; gb++) begin : g_in
            if (gb == CAS_BIT) begin : g_cas
                assign in_vec[gb] = cas_i;
            end else begin : g_zero
                assign in_vec[gb] = 1'b0;
            end
        end
    endgenerate

    assign clr_vec = wr_clr ? wdata : '0;

    // Plain storage registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            route_a_q <= '0;
            route_b_q <= '0;
            mask_q    <= '0;
            pol_q     <= '0;
        end else begin
            if (wr_route_a) route_a_q <= wdata;
            if (wr_route_b) route_b_q <= wdata;
            if (wr_mask)    mask_q    <= wdata;
            if (wr_pol)     pol_q     <= wdata;
        end
    end

    // Sticky status latching only masked inputs.
    always_ff @(posedge clk) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= (stat_q & ~clr_vec) | (in_vec & mask_q);
    end

    // Output reflects any latched bit.
    assign irq_o = (stat_q != '0);
endmodule

// File: rtl/irqc_fw_store.sv
// Firmware window storage: two read/write registers with no function
// beyond holding their value. The size register has a nonzero reset value.
module irqc_fw_store #(
    parameter int            DW       = 32,
    parameter logic [DW-1:0] SIZE_RST = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_seg,
    input  logic          wr_size,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] seg_q,
    output logic [DW-1:0] size_q
);
    // Hold last written values.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seg_q  <= '0;
            size_q <= SIZE_RST;
        end else begin
            if (wr_seg)  seg_q  <= wdata;
            if (wr_size) size_q <= wdata;
        end
    end
endmodule

// File: rtl/irqc_top.sv
// Top: decodes the word-indexed register bus into write strobes for the
// two interrupt stages and the firmware storage, and muxes read data.
// Assumes single-cycle writes; reads are side-effect free.
module irqc_top
    import irqc_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int NLINES = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] widx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [NLINES-1:0] irq_lines,
    output logic              irq_out
);
    logic [DATA_W-1:0] hs_ctrl, hs_mask, hs_stat;
    logic [DATA_W-1:0] ms_route_a, ms_route_b, ms_mask, ms_pol, ms_stat, ms_in;
    logic [DATA_W-1:0] fw_seg, fw_size;
    logic              s1_req;

    // Write strobe decode.
    logic sel_hctrl, sel_hmask, sel_hstat;
    logic sel_ra, sel_rb, sel_mmask, sel_mpol, sel_mstat;
    logic sel_fseg, sel_fsize;

    always_comb begin
        sel_hctrl = wr_en && (widx == ADDR_W'(IDX_HCTRL));
        sel_hmask = wr_en && (widx == ADDR_W'(IDX_HMASK));
        sel_hstat = wr_en && (widx == ADDR_W'(IDX_HSTAT));
        sel_ra    = wr_en && (widx == ADDR_W'(IDX_ROUTE_A));
        sel_rb    = wr_en && (widx == ADDR_W'(IDX_ROUTE_B));
        sel_mmask = wr_en && (widx == ADDR_W'(IDX_MMASK));
        sel_mpol  = wr_en && (widx == ADDR_W'(IDX_MPOL));
        sel_mstat = wr_en && (widx == ADDR_W'(IDX_MSTAT));
        sel_fseg  = wr_en && (widx == ADDR_W'(IDX_FW_SEG));
        sel_fsize = wr_en && (widx == ADDR_W'(IDX_FW_SIZE));
    end

    irqc_host_stage #(
        .DW(DATA_W), .NLINES(NLINES), .EN_BIT(HOST_EN_BIT)
    ) u_host (
        .clk(clk), .rst_n(rst_n),
        .wr_ctrl(sel_hctrl), .wr_mask(sel_hmask), .wr_clr(sel_hstat),
        .wdata(wdata), .lines(irq_lines),
        .ctrl_q(hs_ctrl), .mask_q(hs_mask), .stat_q(hs_stat), .req_o(s1_req)
    );

    irqc_master_stage #(
        .DW(DATA_W), .CAS_BIT(CASCADE_BIT)
    ) u_master (
        .clk(clk), .rst_n(rst_n),
        .wr_route_a(sel_ra), .wr_route_b(sel_rb), .wr_mask(sel_mmask),
        .wr_pol(sel_mpol), .wr_clr(sel_mstat), .wdata(wdata), .cas_i(s1_req),
        .route_a_q(ms_route_a), .route_b_q(ms_route_b), .mask_q(ms_mask),
        .pol_q(ms_pol), .stat_q(ms_stat), .in_vec(ms_in), .irq_o(irq_out)
    );

    irqc_fw_store #(
        .DW(DATA_W), .SIZE_RST(FW_SIZE_RST)
    ) u_fw (
        .clk(clk), .rst_n(rst_n),
        .wr_seg(sel_fseg), .wr_size(sel_fsize), .wdata(wdata),
        .seg_q(fw_seg), .size_q(fw_size)
    );

    // Read data mux; unmapped indices return all ones.
    always_comb begin
        case (widx)
            ADDR_W'(IDX_ROUTE_A): rdata = ms_route_a;
            ADDR_W'(IDX_ROUTE_B): rdata = ms_route_b;
            ADDR_W'(IDX_FW_SEG):  rdata = fw_seg;
            ADDR_W'(IDX_FW_SIZE): rdata = fw_size;
            ADDR_W'(IDX_HCTRL):   rdata = hs_ctrl;
            ADDR_W'(IDX_HMASK):   rdata = hs_mask;
            ADDR_W'(IDX_HSTAT):   rdata = hs_stat;
            ADDR_W'(IDX_ERRADDR): rdata = '0;
            ADDR_W'(IDX_MSTAT):   rdata = ms_stat;
            ADDR_W'(IDX_MMASK):   rdata = ms_mask;
            ADDR_W'(IDX_MPOL):    rdata = ms_pol;
            ADDR_W'(IDX_MINPUT):  rdata = ms_in;
            default:              rdata = UNMAPPED_RD;
        endcase
    end
endmodule

// File: rtl/irqc_chk.sv
// Checker: temporal properties of the two-stage aggregator, bound to the
// top. Assumes inputs are synchronous to clk and known after reset.
module irqc_chk
    import irqc_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int NLINES = 17
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] widx,
    input logic [DATA_W-1:0] wdata,
    input logic [NLINES-1:0] irq_lines,
    input logic              irq_out,
    input logic [DATA_W-1:0] hs_stat,
    input logic [DATA_W-1:0] ms_mask,
    input logic              s1_req
);
    genvar gl;
    generate
        for (gl = 0; gl < NLINES; gl++) begin : g_line
            // R2
            line_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
                irq_lines[gl] |=> hs_stat[DATA_W-1-gl]);
        end
    endgenerate

    // R3
    host_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hs_stat[DATA_W-1] && !(wr_en && widx == ADDR_W'(IDX_HSTAT) && wdata[DATA_W-1]))
        |=> hs_stat[DATA_W-1]);

    // R5
    master_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s1_req && ms_mask[CASCADE_BIT]) |=> irq_out);

    // R6
    master_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_out && !(wr_en && widx == ADDR_W'(IDX_MSTAT))) |=> irq_out);

    // R13
    out_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_out) |-> $past(s1_req && ms_mask[CASCADE_BIT]));
endmodule

bind irqc_top irqc_chk #(.ADDR_W(ADDR_W), .NLINES(NLINES)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .widx(widx), .wdata(wdata),
    .irq_lines(irq_lines), .irq_out(irq_out), .hs_stat(hs_stat),
    .ms_mask(ms_mask), .s1_req(s1_req)
);

// File: tb/irqc_top_bench.sv
module irqc_top_bench;
    localparam int AW = 6;
    localparam int NL = 17;
    localparam int NV = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] widx = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [NL-1:0] irq_lines = '0;
    logic          irq_out;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    irqc_top #(.ADDR_W(AW), .NLINES(NL)) u_irqc_top (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .widx(widx), .wdata(wdata),
        .rdata(rdata), .irq_lines(irq_lines), .irq_out(irq_out)
    );

    // {index, write data, expected read-back}
    localparam logic [69:0] VEC [NV] = '{
        {6'd2,  32'hA5A5_0001, 32'hA5A5_0001},  // R8 route A
        {6'd3,  32'h5A5A_0002, 32'h5A5A_0002},  // R8 route B
        {6'd22, 32'h0000_00FF, 32'h0000_00FF},  // R8 polarity
        {6'd9,  32'h1234_5678, 32'h1234_5678},  // R12 segment
        {6'd10, 32'h0100_0000, 32'h0100_0000},  // R12 read size
        {6'd13, 32'hFFFF_8000, 32'hFFFF_8000},  // R4 host mask
        {6'd21, 32'h0000_0800, 32'h0000_0800},  // R5 master mask
        {6'd23, 32'hFFFF_FFFF, 32'h0000_0000},  // R9 input read-only
        {6'd16, 32'hDEAD_BEEF, 32'h0000_0000},  // R11 error address
        {6'd0,  32'hFFFF_0000, 32'hFFFF_FFFF},  // R10 unmapped
        {6'd15, 32'h0000_0000, 32'hFFFF_FFFF},  // R10 unmapped
        {6'd63, 32'h0000_0001, 32'hFFFF_FFFF}   // R10 unmapped
    };

    function automatic string tag_of(input logic [5:0] i);
        case (i)
            6'd2, 6'd3, 6'd22: return "R8";
            6'd9, 6'd10:       return "R12";
            6'd13:             return "R4";
            6'd21:             return "R5";
            6'd23:             return "R9";
            6'd16:             return "R11";
            default:           return "R10";
        endcase
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic wr(input int i, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; widx = AW'(i); wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int i, output logic [31:0] d);
        widx = AW'(i);
        #1 d = rdata;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL R13 watchdog actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        do_reset();

        // R1 reset state
        chk("R1 irq_out", {31'd0, irq_out}, 32'd0);
        foreach (VEC[k]) begin
            rd(int'(VEC[k][69:64]), v);
            if (VEC[k][69:64] == 6'd10)      chk("R1 fw size", v, 32'h0200_0000);
            else if (VEC[k][31:0] != '1)     chk("R1 reg", v, 32'd0);
        end
        rd(12, v); chk("R1 ctrl", v, 0);
        rd(14, v); chk("R1 hstat", v, 0);
        rd(20, v); chk("R1 mstat", v, 0);

        // Table walk: storage, read-only and unmapped indices
        for (int k = 0; k < NV; k++) begin
            wr(int'(VEC[k][69:64]), VEC[k][63:32]);
            rd(int'(VEC[k][69:64]), v);
            chk(tag_of(VEC[k][69:64]), v, VEC[k][31:0]);
        end
        rd(13, v); chk("R10 mask kept", v, 32'hFFFF_8000);
        chk("R8 irq after pol", {31'd0, irq_out}, 32'd0);

        do_reset();
        // R2 line 0 pulse, then line 16
        @(negedge clk) irq_lines[0] = 1'b1;
        @(negedge clk) irq_lines[0] = 1'b0;
        rd(14, v); chk("R2 line0", v, 32'h8000_0000);
        @(negedge clk) irq_lines[16] = 1'b1;
        @(negedge clk) irq_lines[16] = 1'b0;
        @(negedge clk);
        rd(14, v); chk("R2 line16 sticky", v, 32'h8000_8000);
        rd(23, v); chk("R4 disabled", v, 0);

        // R4 mask set but enable off, then enable on
        wr(13, 32'h8000_0000);
        rd(23, v); chk("R4 enable off", v, 0);
        wr(12, 32'h8000_0000);
        rd(23, v); chk("R4 request", v, 32'h0000_0800);
        @(negedge clk); @(negedge clk);
        chk("R5 unmasked not latched", {31'd0, irq_out}, 0);

        // R5/R7 master mask latches
        wr(21, 32'h0000_0800);
        @(negedge clk);
        rd(20, v); chk("R5 latched", v, 32'h0000_0800);
        chk("R7 irq high", {31'd0, irq_out}, 1);

        // R9 write ignored while request live
        wr(23, 32'h0);
        rd(23, v); chk("R9 input live", v, 32'h0000_0800);

        // R3 clear host; R5 master sticky
        wr(14, 32'h8000_8000);
        rd(14, v); chk("R3 cleared", v, 0);
        @(negedge clk);
        rd(20, v); chk("R5 sticky", v, 32'h0000_0800);

        // R8 polarity/route writes do not drop irq
        wr(22, 32'hFFFF_FFFF);
        wr(2, 32'hFFFF_FFFF);
        chk("R8 irq unaffected", {31'd0, irq_out}, 1);

        // R6 zero write no effect, then W1C
        wr(20, 32'h0);
        rd(20, v); chk("R6 zero write", v, 32'h0000_0800);
        wr(20, 32'h0000_0800);
        rd(20, v); chk("R6 cleared", v, 0);
        chk("R7 irq low", {31'd0, irq_out}, 0);

        // R13 latency: edge k latches host, edge k+1 raises irq_out
        @(negedge clk) irq_lines[0] = 1'b1;
        @(negedge clk) irq_lines[0] = 1'b0;
        rd(14, v); chk("R13 host after k", v, 32'h8000_0000);
        chk("R13 irq not yet", {31'd0, irq_out}, 0);
        @(negedge clk);
        chk("R13 irq after k+1", {31'd0, irq_out}, 1);

        // R3 set wins while line held
        @(negedge clk) irq_lines[0] = 1'b1;
        wr(14, 32'h8000_0000);
        rd(14, v); chk("R3 held line", v, 32'h8000_0000);
        irq_lines[0] = 1'b0;
        wr(14, 32'h8000_0000);
        rd(14, v); chk("R3 cleared after drop", v, 0);
        wr(20, 32'h0000_0800);
        @(negedge clk);
        chk("R6 final clear", {31'd0, irq_out}, 0);

        // R4 disable gates request with latched status
        @(negedge clk) irq_lines[0] = 1'b1;
        @(negedge clk) irq_lines[0] = 1'b0;
        wr(12, 32'h0);
        rd(23, v); chk("R4 gated", v, 0);

        done = 1'b1;
        summary();
        $finish;
    end
endmodule